// File: doc/BRIEF.md
# Byte-to-Word Data Transfer Engine

This block moves payload between a bus-visible FIFO of 32-bit words and a card data port that carries one byte per accepted beat. When the direction bit selects card-to-FIFO, incoming card bytes are packed into words, lowest byte lane first, and pushed into the FIFO. The bus then drains them through a 16-word data window. When the direction bit selects FIFO-to-card, the bus fills the FIFO through the same window and the engine unpacks each word onto the card port, again lowest lane first.

Two counters run side by side. A byte counter follows the card side. A word counter follows the bus side and is loaded with the byte length rounded up to whole words. Starting a transfer means writing the length register and then writing the control register with its enable bit set. Once the byte counter runs out, a data-end flag and a block-end flag are raised. When both counters have reached zero, the engine clears its own enable bit.

Register map by byte offset: length at 0x00, control at 0x04, byte counter at 0x08 (read only), word counter at 0x0C (read only), status at 0x10 (write 1 to clear), and the FIFO window from 0x40 to 0x7C. Any other offset reads as zero.

Top module: `byte_word_mover`

## Requirements
- R1: After reset, every register reads 0, the FIFO is empty, and neither `cardInReady` nor `cardOutValid` is asserted.
- R2: The control register keeps bits 7:0, with bit 0 as enable, bit 1 as direction (1 = card to FIFO), and bits 2 and 3 stored only. The length register keeps bits 15:0. A control write with bit 0 set loads the byte counter with the length and the word counter with (length + 3) >> 2.
- R3: In card-to-FIFO mode, byte k of each group of four lands in word bits 8k+7:8k.
- R4: In card-to-FIFO mode, a final word short of four bytes is still pushed, with its unfilled upper lanes at zero.
- R5: In card-to-FIFO mode, `cardInReady` is low while the FIFO holds 16 words. While `cardInValid` is low, no byte is taken and the byte counter holds.
- R6: In FIFO-to-card mode, each word leaves the card port bits 7:0 first. `cardOutValid` stays low while the FIFO is empty and no bytes of a word remain to be sent.
- R7: A window read in card-to-FIFO mode returns the oldest FIFO word, pops it, and decrements the word counter. A window write in FIFO-to-card mode pushes a word and decrements the word counter.
- R8: A window access while the word counter is 0 is ignored and a read of the window returns 0.
- R9: All 16 window word addresses, 0x40 through 0x7C, reach the same FIFO.
- R10: When the byte counter is 0 while enable is set, status bit 8 (data end) and bit 10 (block end) are set. Writing 1 to those bits at the status offset clears them.
- R11: Enable clears by itself once both counters are 0.
- R12: A window write on a full FIFO and a window read on an empty FIFO are blocked and change neither the FIFO nor the word counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Bus access strobe, one access per cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| cardInValid | input | 1 | Card offers a byte |
| cardInData | input | 8 | Byte from the card |
| cardInReady | output | 1 | Engine takes the offered byte |
| cardOutValid | output | 1 | Engine offers a byte to the card |
| cardOutData | output | 8 | Byte to the card |
| cardOutReady | input | 1 | Card takes the offered byte |

## Verification
Transfers are run in both directions at lengths of 1, 3, 4, 6, 7, 13 and 64 bytes, and the byte values differ at every position.
- Lengths that are whole words check the lane order.
- Lengths with a remainder of 1, 2 or 3 bytes show whether a partial word is pushed, zero-padded, or dropped.
- Window addresses rotate through all 16 slots, so an address decode that treats slots differently shows up.
- A 68-byte transfer in each direction fills the FIFO. It shows whether back-pressure, the blocked push and the two independent counters hold up when the FIFO is full.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int OFS_LEN    = 'h00;
  localparam int OFS_CTRL   = 'h04;
  localparam int OFS_BCNT   = 'h08;
  localparam int OFS_WCNT   = 'h0C;
  localparam int OFS_STAT   = 'h10;
  localparam int ST_END_BIT = 8;
  localparam int ST_BLK_BIT = 10;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic dirRx;
    logic moving;
    logic lastByte;
    logic busPush;
    logic busPop;
  } bwmStrobe_t;

  // feedback from datapath to control
  typedef struct packed {
    logic fifoFull;
    logic fifoEmpty;
    logic byteBeat;
  } bwmDpStat_t;
endpackage

// File: rtl/bwm_datapath.sv
module bwm_datapath
  import bwm_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bwmStrobe_t        stb,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] headWord,
  output bwmDpStat_t        dpStat,
  input  logic              cardInValid,
  input  logic [BYTE_W-1:0] cardInData,
  output logic              cardInReady,
  output logic              cardOutValid,
  output logic [BYTE_W-1:0] cardOutData,
  input  logic              cardOutReady
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;
  logic              fifoFull, fifoEmpty;

  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] packWord, packNext;
  logic [WORD_W-1:0] heldWord;
  logic [LANE_W-1:0] heldLeft;
  logic              txHeld;

  logic rxBeat, rxPush, txBeat, txPop, push, pop;
  logic [WORD_W-1:0] pushWord;

  assign fifoFull  = (fill == CNT_W'(DEPTH));
  assign fifoEmpty = (fill == '0);
  assign headWord  = mem[rdPtr];

  // card to FIFO packing
  assign cardInReady = stb.moving & stb.dirRx & ~fifoFull;
  assign rxBeat      = cardInReady & cardInValid;
  assign rxPush      = rxBeat & ((lane == LANE_W'(LANES - 1)) | stb.lastByte);

  always_comb begin
    packNext = (lane == '0) ? '0 : packWord;
    packNext[lane*BYTE_W +: BYTE_W] = cardInData;
  end

  // FIFO to card unpacking
  assign txHeld       = (heldLeft != '0);
  assign cardOutValid = stb.moving & ~stb.dirRx & (txHeld | ~fifoEmpty);
  assign cardOutData  = txHeld ? heldWord[BYTE_W-1:0] : headWord[BYTE_W-1:0];
  assign txBeat       = cardOutValid & cardOutReady;
  assign txPop        = txBeat & ~txHeld;

  assign push     = rxPush | stb.busPush;
  assign pop      = txPop | stb.busPop;
  assign pushWord = rxPush ? packNext : busWdata;

  assign dpStat.fifoFull  = fifoFull;
  assign dpStat.fifoEmpty = fifoEmpty;
  assign dpStat.byteBeat  = rxBeat | txBeat;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lane     <= '0;
      packWord <= '0;
      heldWord <= '0;
      heldLeft <= '0;
    end else if (stb.restart) begin
      lane     <= '0;
      heldLeft <= '0;
    end else begin
      if (rxBeat) begin
        lane     <= lane + 1'b1;
        packWord <= packNext;
      end
      if (txPop) begin
        heldWord <= headWord >> BYTE_W;
        heldLeft <= LANE_W'(LANES - 1);
      end else if (txBeat) begin
        heldWord <= heldWord >> BYTE_W;
        heldLeft <= heldLeft - 1'b1;
      end
    end
  end

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !(rxPush || stb.busPush));
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> !(txPop || stb.busPop));
  p_single_push_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(rxPush && stb.busPush));
  p_rx_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !cardInReady);
  p_tx_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && !txHeld) |-> !cardOutValid);
endmodule

// File: rtl/bwm_ctrl.sv
module bwm_ctrl
  import bwm_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LANES  = 4,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        ctrlBits,
  input  logic              clrEnd,
  input  logic              clrBlk,
  input  logic [WORD_W-1:0] headWord,
  input  bwmDpStat_t        dpStat,
  output bwmStrobe_t        stb,
  output logic [WORD_W-1:0] busRdata
);
  localparam int LANE_W    = $clog2(LANES);
  localparam int WCNT_W    = LEN_W - LANE_W + 1;
  localparam int WIN_SHIFT = $clog2(DEPTH * LANES);

  logic [LEN_W-1:0]  lenReg, byteCnt;
  logic [WCNT_W-1:0] wordCnt, wordLoad;
  logic [LEN_W:0]    lenExt;
  logic [7:0]        ctrlReg;
  logic              endFlag, blkFlag;

  logic wr, rd, lenHit, ctrlHit, bcntHit, wcntHit, statHit, winHit;
  logic enable, dirRx, wordsLeft;

  assign wr      = busEn & busWe;
  assign rd      = busEn & ~busWe;
  assign lenHit  = (busAddr == ADDR_W'(OFS_LEN));
  assign ctrlHit = (busAddr == ADDR_W'(OFS_CTRL));
  assign bcntHit = (busAddr == ADDR_W'(OFS_BCNT));
  assign wcntHit = (busAddr == ADDR_W'(OFS_WCNT));
  assign statHit = (busAddr == ADDR_W'(OFS_STAT));
  assign winHit  = ((busAddr >> WIN_SHIFT) == ADDR_W'(1));

  assign enable    = ctrlReg[0];
  assign dirRx     = ctrlReg[1];
  assign wordsLeft = (wordCnt != '0);

  assign lenExt   = {1'b0, lenReg} + (LEN_W + 1)'(LANES - 1);
  assign wordLoad = lenExt[LEN_W:LANE_W];

  assign stb.restart  = wr & ctrlHit & ctrlBits[0];
  assign stb.dirRx    = dirRx;
  assign stb.moving   = enable & (byteCnt != '0);
  assign stb.lastByte = (byteCnt == LEN_W'(1));
  assign stb.busPush  = wr & winHit & ~dirRx & wordsLeft & ~dpStat.fifoFull;
  assign stb.busPop   = rd & winHit & dirRx & wordsLeft & ~dpStat.fifoEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg  <= '0;
      ctrlReg <= '0;
      byteCnt <= '0;
      wordCnt <= '0;
      endFlag <= 1'b0;
      blkFlag <= 1'b0;
    end else begin
      if (wr && lenHit) lenReg <= busWdata16();

      if (wr && ctrlHit)
        ctrlReg <= ctrlBits;
      else if (enable && byteCnt == '0 && !wordsLeft)
        ctrlReg[0] <= 1'b0;

      if (stb.restart)          byteCnt <= lenReg;
      else if (dpStat.byteBeat) byteCnt <= byteCnt - 1'b1;

      if (stb.restart)                      wordCnt <= wordLoad;
      else if (stb.busPush || stb.busPop)   wordCnt <= wordCnt - 1'b1;

      if (enable && byteCnt == '0) begin
        endFlag <= 1'b1;
        blkFlag <= 1'b1;
      end else if (wr && statHit) begin
        if (clrEnd) endFlag <= 1'b0;
        if (clrBlk) blkFlag <= 1'b0;
      end
    end
  end

  // length is written through the low bits carried alongside the control bits
  logic [LEN_W-1:0] lenWdata;
  function automatic logic [LEN_W-1:0] busWdata16();
    return lenWdata;
  endfunction

  always_comb begin
    busRdata = '0;
    if (rd) begin
      if (lenHit)       busRdata = WORD_W'(lenReg);
      else if (ctrlHit) busRdata = WORD_W'(ctrlReg);
      else if (bcntHit) busRdata = WORD_W'(byteCnt);
      else if (wcntHit) busRdata = WORD_W'(wordCnt);
      else if (statHit) begin
        busRdata[ST_END_BIT] = endFlag;
        busRdata[ST_BLK_BIT] = blkFlag;
      end else if (winHit && stb.busPop) busRdata = headWord;
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> (byteCnt == $past(lenReg)));
  p_bytecnt_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dpStat.byteBeat && !stb.restart) |=> (byteCnt == $past(byteCnt) - LEN_W'(1)));
  p_zero_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wordCnt == '0) |-> !(stb.busPush || stb.busPop));
  p_autoclear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (enable && byteCnt == '0 && wordCnt == '0 && !(wr && ctrlHit)) |=> !ctrlReg[0]);
  p_dataend_r10: assert property (@(posedge clk) disable iff (!rstN)
    (enable && byteCnt == '0) |=> (endFlag && blkFlag));
endmodule

// File: rtl/byte_word_mover.sv
module byte_word_mover
  import bwm_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic              cardInValid,
  input  logic [BYTE_W-1:0] cardInData,
  output logic              cardInReady,
  output logic              cardOutValid,
  output logic [BYTE_W-1:0] cardOutData,
  input  logic              cardOutReady
);
  localparam int LANES = WORD_W / BYTE_W;

  bwmStrobe_t        stb;
  bwmDpStat_t        dpStat;
  logic [WORD_W-1:0] headWord;

  bwm_ctrl #(
    .DEPTH(DEPTH), .WORD_W(WORD_W), .LANES(LANES), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busEn    (busEn),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .ctrlBits (busWdata[7:0]),
    .clrEnd   (busWdata[ST_END_BIT]),
    .clrBlk   (busWdata[ST_BLK_BIT]),
    .headWord (headWord),
    .dpStat   (dpStat),
    .stb      (stb),
    .busRdata (busRdata)
  );

  assign uCtrl.lenWdata = busWdata[LEN_W-1:0];

  bwm_datapath #(
    .DEPTH(DEPTH), .WORD_W(WORD_W), .BYTE_W(BYTE_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .busWdata     (busWdata),
    .headWord     (headWord),
    .dpStat       (dpStat),
    .cardInValid  (cardInValid),
    .cardInData   (cardInData),
    .cardInReady  (cardInReady),
    .cardOutValid (cardOutValid),
    .cardOutData  (cardOutData),
    .cardOutReady (cardOutReady)
  );
endmodule

// File: tb/tb_byte_word_mover.sv
module tb_byte_word_mover;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0, busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        cardInValid = 1'b0;
  logic [7:0]  cardInData = '0;
  logic        cardInReady;
  logic        cardOutValid;
  logic [7:0]  cardOutData;
  logic        cardOutReady = 1'b0;

  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_LEN = 8'h00, A_CTRL = 8'h04, A_BCNT = 8'h08,
                         A_WCNT = 8'h0C, A_STAT = 8'h10, A_WIN = 8'h40;

  // {dirRx, length, seed}
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 16'd4,  8'h10}, {1'b1, 16'd1,  8'hA5},
    {1'b1, 16'd7,  8'h30}, {1'b1, 16'd64, 8'h00},
    {1'b0, 16'd4,  8'h50}, {1'b0, 16'd6,  8'h60},
    {1'b0, 16'd13, 8'h70}, {1'b1, 16'd3,  8'hF0}
  };

  byte_word_mover dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bexp(logic [7:0] seed, int i);
    return 8'(seed + i * 3);
  endfunction

  function automatic logic [31:0] wexp(logic [7:0] seed, int w, int len, logic [7:0] pad);
    logic [31:0] v;
    for (int k = 0; k < 4; k++)
      v[k*8 +: 8] = (4*w + k < len) ? bexp(seed, 4*w + k) : pad;
    return v;
  endfunction

  task automatic busWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busEn = 1; busWe = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busEn = 0; busWe = 0;
  endtask

  task automatic busRd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busEn = 1; busWe = 0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busEn = 0;
  endtask

  task automatic sendByte(logic [7:0] b);
    @(negedge clk);
    cardInValid = 1; cardInData = b;
    while (!cardInReady) @(negedge clk);
    @(posedge clk); #1;
    cardInValid = 0;
  endtask

  task automatic getByte(output logic [7:0] b);
    @(negedge clk);
    cardOutReady = 1;
    while (!cardOutValid) @(negedge clk);
    b = cardOutData;
    @(posedge clk); #1;
    cardOutReady = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic endChecks(logic dir);
    logic [31:0] r;
    idle(3);
    busRd(A_STAT, r); chk("R10 end flags", r, 32'h500);
    busRd(A_CTRL, r); chk("R11 enable cleared", r, {30'd0, dir, 1'b0});
    busWr(A_STAT, 32'h500);
    busRd(A_STAT, r); chk("R10 flags cleared", r, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  b;
    idle(3);
    rstN = 1;
    idle(1);

    // R1 reset state
    #1;
    chk("R1 cardInReady", {31'd0, cardInReady}, 0);
    chk("R1 cardOutValid", {31'd0, cardOutValid}, 0);
    busRd(A_LEN, r);  chk("R1 length", r, 0);
    busRd(A_CTRL, r); chk("R1 control", r, 0);
    busRd(A_BCNT, r); chk("R1 byte count", r, 0);
    busRd(A_WCNT, r); chk("R1 word count", r, 0);
    busRd(A_STAT, r); chk("R1 status", r, 0);

    // R2 register widths
    busWr(A_LEN, 32'h0001_2345);
    busRd(A_LEN, r);  chk("R2 length width", r, 32'h2345);
    busWr(A_CTRL, 32'hFFFF_FF0C);
    busRd(A_CTRL, r); chk("R2 control width", r, 32'h0C);
    busRd(A_BCNT, r); chk("R2 no load without enable", r, 0);

    // R8 window access with zero word count
    busRd(A_WIN, r);  chk("R8 read at zero count", r, 0);
    busWr(A_WIN + 8'h08, 32'hDEAD_BEEF);
    busWr(A_LEN, 4);
    busWr(A_CTRL, 32'h1);
    busWr(A_WIN, 32'h4433_2211);
    for (int i = 0; i < 4; i++) begin
      getByte(b);
      chk("R8 ignored write kept out", {24'd0, b}, 32'(8'h11 * (i + 1)));
    end
    endChecks(1'b0);

    // zero length: flags and enable clear at once (R10, R11)
    busWr(A_LEN, 0);
    busWr(A_CTRL, 32'h3);
    endChecks(1'b1);

    // vector table: both directions, several lengths (R2 R3 R4 R6 R7 R9)
    for (int v = 0; v < 8; v++) begin
      logic       dir;
      int         len, nw;
      logic [7:0] seed;
      dir  = VEC[v][24];
      len  = int'(VEC[v][23:8]);
      seed = VEC[v][7:0];
      nw   = (len + 3) / 4;
      busWr(A_LEN, 32'(len));
      busWr(A_CTRL, {30'd0, dir, 1'b1});
      busRd(A_BCNT, r); chk("R2 byte count load", r, 32'(len));
      busRd(A_WCNT, r); chk("R2 word count load", r, 32'(nw));
      if (dir) begin
        for (int i = 0; i < len; i++) sendByte(bexp(seed, i));
        for (int w = 0; w < nw; w++) begin
          busRd(8'(A_WIN + 4 * ((w + v) % 16)), r);
          chk("R3 R4 R9 packed word", r, wexp(seed, w, len, 8'h00));
        end
      end else begin
        for (int w = 0; w < nw; w++)
          busWr(8'(A_WIN + 4 * ((w + v) % 16)), wexp(seed, w, len, 8'hEE));
        busRd(A_WCNT, r); chk("R7 word count after pushes", r, 0);
        for (int i = 0; i < len; i++) begin
          getByte(b);
          chk("R6 byte order", {24'd0, b}, {24'd0, bexp(seed, i)});
        end
      end
      endChecks(dir);
    end

    // R5 stall on full FIFO and on no data, 68-byte read
    busWr(A_LEN, 68);
    busWr(A_CTRL, 32'h3);
    for (int i = 0; i < 64; i++) sendByte(bexp(8'h21, i));
    @(negedge clk);
    cardInValid = 1; cardInData = 8'h99;
    #1 chk("R5 ready low when full", {31'd0, cardInReady}, 0);
    cardInValid = 0;
    idle(3);
    busRd(A_BCNT, r); chk("R5 byte count holds", r, 4);
    busRd(A_WIN + 8'h3C, r); chk("R7 first word", r, wexp(8'h21, 0, 68, 8'h00));
    busRd(A_WCNT, r); chk("R7 word count decrement", r, 16);
    for (int i = 64; i < 68; i++) sendByte(bexp(8'h21, i));
    for (int w = 1; w < 17; w++) begin
      busRd(8'(A_WIN + 4 * (w % 16)), r);
      if (w == 16) chk("R5 last word after stall", r, wexp(8'h21, 16, 68, 8'h00));
    end
    endChecks(1'b1);

    // R12 push on full blocked, 68-byte write
    busWr(A_LEN, 68);
    busWr(A_CTRL, 32'h1);
    for (int w = 0; w < 16; w++) busWr(8'(A_WIN + 4 * w), wexp(8'h07, w, 68, 8'hEE));
    busWr(A_WIN, 32'hBAD0_BAD0);
    busRd(A_WCNT, r); chk("R12 blocked push keeps count", r, 1);
    for (int i = 0; i < 4; i++) getByte(b);
    chk("R12 byte 3", {24'd0, b}, {24'd0, bexp(8'h07, 3)});
    busWr(A_WIN, wexp(8'h07, 16, 68, 8'hEE));
    busRd(A_WCNT, r); chk("R7 word count to zero", r, 0);
    for (int i = 4; i < 68; i++) begin
      getByte(b);
      if (i == 63 || i == 64 || i == 67)
        chk("R12 stream after block", {24'd0, b}, {24'd0, bexp(8'h07, i)});
    end
    endChecks(1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule